// File: doc/BRIEF.md
# Write-Only I2C Control Register Target

This block is an I2C target that only accepts writes. It fills a bank of 22 eight-bit control registers at addresses 00h to 15h, and every register appears on a flat output bus for the logic around it. SCL and SDA are sampled by the system clock, which must run at least 8 times faster than SCL. START and STOP conditions are found from SDA edges while SCL is high. The target does not drive SDA itself: it asks for the line to be pulled low through an output-enable signal, and an open-drain pad outside the block does the pulling.

A write transfer has three parts. The first byte carries the 7-bit device address, with the R/W bit as its last bit. The second byte loads the register pointer. Every byte after that is written to the register the pointer names, and the pointer then advances by one. A pin picks the least significant bit of the device address, so two of these targets can share one bus.

Top module: `i2cw_target`

## Requirements
- R1: While reset is active (`rst_n` low, sampled on the clock), every register reads 00h and `sda_pull` stays 0.
- R2: The device address is 0011010 with `addr_pick` low and 0011011 with `addr_pick` high. An address byte is sent MSB first, as those seven bits followed by R/W = 0. Such a byte is acknowledged: `sda_pull` is 1 during the ninth SCL clock.
- R3: An address byte with the wrong address, or with R/W = 1, is not acknowledged. Until the next START or STOP, no later byte is acknowledged and no register changes.
- R4: `sda_pull` changes only while SCL is low.
- R5: The byte after an accepted address loads the pointer. The next byte, taken MSB first, is written to the register the pointer names. Both bytes are acknowledged.
- R6: Each further data byte in the same transfer goes to the next address up.
- R7: A data byte written at address 15h sets the pointer to 00h, so the following byte lands in register 00h.
- R8: A data byte aimed at an address from 16h to FFh is acknowledged, changes no register, and still advances the pointer. From FFh the pointer wraps to 00h.
- R9: A repeated START restarts address reception. Registers already written keep their values.
- R10: After a STOP, the target does not acknowledge a byte clocked on the bus without a new START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL level as seen at the pad |
| sda_in | input | 1 | SDA level as seen at the pad |
| addr_pick | input | 1 | Chooses the device address LSB |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| regs_flat | output | 176 | Register i is at bits [8i+7:8i] |

## Verification
Some behaviour can be checked on every cycle, and the bound checker does so. It checks that `sda_pull` moves only while SCL is low, that a skipped transfer never pulls SDA, and that the registers change only in the cycle after a write strobe. It also checks that a write at 15h leaves the pointer at 00h, and that reset clears the bank and releases SDA.

Other behaviour shows only across whole transfers, so the bench's bus scenarios cover it. That includes address decoding for both pin settings and rejection of reads and foreign addresses. It also includes bursts that cross 15h, discarding of writes to unimplemented addresses, the pointer wrapping from FFh, a repeated START in the middle of a transfer, and silence after a STOP.

// File: rtl/i2cw_pkg.sv
// Package: shared types for the write-only I2C target.
// Assumes: bytes are 8 bits; the phase tracks the position within a transfer.
package i2cw_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,    // no transfer in progress
        ST_BITS,    // shifting in the bits of a byte
        ST_HOLD,    // eighth bit taken, waiting for SCL to fall
        ST_ACK,     // ninth clock, acknowledge in progress
        ST_SKIP     // not addressed, wait for START or STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,    // next byte is the device address
        PH_PTR,     // next byte is the register pointer
        PH_DATA     // next byte is register data
    } rx_phase_t;
endpackage

// File: rtl/i2cw_sync.sv
// Module: i2cw_sync
// Purpose: two-flop synchronizer with edge detection for each line.
// Assumes: the lines idle high, so reset loads ones into every flop.
module i2cw_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic meta, stab, prev;

        // Resynchronize the line and remember its last level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta <= 1'b1;
                stab <= 1'b1;
                prev <= 1'b1;
            end else begin
                meta <= din[g];
                stab <= meta;
                prev <= stab;
            end
        end

        assign lvl[g]  = stab;
        assign rise[g] = stab & ~prev;
        assign fall[g] = ~stab & prev;
    end
endmodule

// File: rtl/i2cw_rx_fsm.sv
// Module: i2cw_rx_fsm
// Purpose: decodes the bus into address, pointer and data bytes.
// It drives the acknowledge and issues one write strobe per data byte.
// Assumes: the SCL and SDA inputs are already synchronized; SCL low phases
// span several clocks, so SCL is low when sda_pull changes.
module i2cw_rx_fsm
    import i2cw_pkg::*;
#(
    parameter int         NUM_REGS = 22,
    parameter logic [6:0] DEV_ADDR = 7'b0011010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic              addr_pick,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ptr,
    output logic              skipping
);
    localparam logic [BYTE_W-1:0] LAST_ADDR = BYTE_W'(NUM_REGS - 1);

    rx_state_t         st;
    rx_phase_t         phase;
    logic [2:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              start_ev, stop_ev, addr_hit;
    logic [BYTE_W-1:0] ptr_next;

    // Bus conditions and decodes taken from the synchronized lines.
    always_comb begin
        start_ev = sda_fall & scl_lvl;
        stop_ev  = sda_rise & scl_lvl;
        addr_hit = (shreg[7:1] == {DEV_ADDR[6:1], addr_pick}) && !shreg[0];
        ptr_next = (ptr == LAST_ADDR) ? '0 : ptr + 1'b1;
    end

    assign skipping = (st == ST_SKIP);

    // Main receive sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            phase    <= PH_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            ptr      <= '0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                st       <= ST_BITS;
                phase    <= PH_ADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (stop_ev) begin
                st       <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (st)
                    ST_BITS: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == 3'd7) st <= ST_HOLD;
                        end
                    end
                    ST_HOLD: begin
                        if (scl_fall) begin
                            case (phase)
                                PH_ADDR: begin
                                    if (addr_hit) begin
                                        phase    <= PH_PTR;
                                        sda_pull <= 1'b1;
                                        st       <= ST_ACK;
                                    end else begin
                                        st <= ST_SKIP;
                                    end
                                end
                                PH_PTR: begin
                                    ptr      <= shreg;
                                    phase    <= PH_DATA;
                                    sda_pull <= 1'b1;
                                    st       <= ST_ACK;
                                end
                                default: begin
                                    wr_en    <= 1'b1;
                                    wr_addr  <= ptr;
                                    wr_data  <= shreg;
                                    ptr      <= ptr_next;
                                    sda_pull <= 1'b1;
                                    st       <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                            st       <= ST_BITS;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cw_regbank.sv
// Module: i2cw_regbank
// Purpose: NUM_REGS byte registers written by address strobe.
// Assumes: a write to an address at or above NUM_REGS is dropped.
module i2cw_regbank #(
    parameter int NUM_REGS = 22,
    parameter int BYTE_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [BYTE_W-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [BYTE_W-1:0] val;

        // Load this register when the strobe names it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    val <= '0;
            else if (wr_en && (wr_addr == BYTE_W'(i)))     val <= wr_data;
        end

        assign regs_flat[i*BYTE_W +: BYTE_W] = val;
    end
endmodule

// File: rtl/i2cw_target.sv
// Module: i2cw_target (top)
// Purpose: write-only I2C target feeding a bank of control registers.
// Assumes: clk is at least 8x SCL; an external open-drain pad pulls SDA low
// while sda_pull is 1.
module i2cw_target
    import i2cw_pkg::*;
#(
    parameter int         NUM_REGS = 22,
    parameter logic [6:0] DEV_ADDR = 7'b0011010
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_in,
    input  logic                       sda_in,
    input  logic                       addr_pick,
    output logic                       sda_pull,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
    logic [1:0]        lvl, rise, fall;
    logic              wr_en, skipping;
    logic [BYTE_W-1:0] wr_addr, wr_data, ptr;

    i2cw_sync #(.WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({sda_in, scl_in}),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    i2cw_rx_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(lvl[0]), .scl_rise(rise[0]), .scl_fall(fall[0]),
        .sda_lvl(lvl[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
        .addr_pick(addr_pick), .sda_pull(sda_pull),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ptr(ptr), .skipping(skipping)
    );

    i2cw_regbank #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .regs_flat(regs_flat)
    );
endmodule

// File: rtl/i2cw_chk.sv
// Module: i2cw_chk
// Purpose: cycle-level properties of i2cw_target, attached by bind.
module i2cw_chk #(
    parameter int NUM_REGS = 22
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_in,
    input logic                  sda_pull,
    input logic                  wr_en,
    input logic [7:0]            wr_addr,
    input logic [7:0]            ptr,
    input logic                  skipping,
    input logic [NUM_REGS*8-1:0] regs_flat
);
    // R1
    regs_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (regs_flat == '0 && !sda_pull));

    // R4
    ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_in);

    // R3
    skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skipping |-> !sda_pull);

    // R5
    reg_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_flat) |-> $past(wr_en));

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'(NUM_REGS - 1)) |-> (ptr == 8'h00));
endmodule

bind i2cw_target i2cw_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull),
    .wr_en(wr_en), .wr_addr(wr_addr), .ptr(ptr), .skipping(skipping),
    .regs_flat(regs_flat)
);

// File: tb/test_i2cw_target.sv
// Bench: drives I2C write transfers and compares the register bank
// against a model the bench keeps itself.
module test_i2cw_target;
    localparam int NREG = 22;
    localparam int Q    = 10;   // clocks per bus phase

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, pick = 1'b0;
    logic sda_pull;
    logic [NREG*8-1:0] regs_flat;
    wire  sda_line = sda_m & ~sda_pull;

    int   n_run = 0, n_fail = 0;
    logic [7:0] mdl [NREG];

    always #2.5 clk = ~clk;

    i2cw_target i_i2cw_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .addr_pick(pick), .sda_pull(sda_pull), .regs_flat(regs_flat)
    );

    // Vector: {pick, addr byte, pointer, data, expect ack}
    localparam logic [25:0] VEC [5] = '{
        {1'b0, 8'h34, 8'h03, 8'hA5, 1'b1},   // R2 address with pin low
        {1'b1, 8'h36, 8'h10, 8'h3C, 1'b1},   // R2 address with pin high
        {1'b0, 8'h36, 8'h05, 8'hFF, 1'b0},   // R3 wrong address
        {1'b0, 8'h35, 8'h06, 8'h77, 1'b0},   // R3 read bit set
        {1'b0, 8'h34, 8'h15, 8'h81, 1'b1}    // R5 last register
    };

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq();
        sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(); scl = 1'b0;
        end
        wq(); sda_m = 1'b1; wq();
        ack = !sda_line;
        scl = 1'b1; wq(); scl = 1'b0; wq();
    endtask

    task automatic check_bank(input string req);
        bit ok = 1'b1;
        for (int i = 0; i < NREG; i++) begin
            if (regs_flat[i*8 +: 8] !== mdl[i]) begin
                ok = 1'b0;
                $display("FAIL %s reg %0h actual=%0h expected=%0h",
                         req, i, regs_flat[i*8 +: 8], mdl[i]);
            end
        end
        n_run++;
        if (!ok) n_fail++;
    endtask

    task automatic send_chk(input logic [7:0] b, input bit exp, input string req);
        bit a;
        send(b, a);
        chk(a == exp, req, a, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        bit a;
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(sda_pull == 1'b0, "R1", sda_pull, 0);
        check_bank("R1");
        rst_n = 1'b1;
        wq();

        // Table walk: single-byte writes and rejected addresses
        for (int v = 0; v < 5; v++) begin
            logic [25:0] e = VEC[v];
            pick = e[25];
            bus_start();
            send_chk(e[24:17], e[0], "R2/R3 addr");
            send_chk(e[16:9],  e[0], "R5/R3 ptr");
            send_chk(e[8:1],   e[0], "R5/R3 data");
            bus_stop();
            if (e[0]) mdl[e[16:9]] = e[8:1];
            check_bank("R5/R3 bank");
        end
        pick = 1'b0;

        // R6 R7 burst crossing the last address
        bus_start();
        send_chk(8'h34, 1, "R6 addr");
        send_chk(8'h13, 1, "R6 ptr");
        send_chk(8'h11, 1, "R6 data");
        send_chk(8'h22, 1, "R6 data");
        send_chk(8'h33, 1, "R7 data");
        send_chk(8'h44, 1, "R7 data");
        bus_stop();
        mdl[8'h13] = 8'h11; mdl[8'h14] = 8'h22;
        mdl[8'h15] = 8'h33; mdl[8'h00] = 8'h44;
        check_bank("R7 wrap");

        // R8 unimplemented addresses, wrap from FF
        bus_start();
        send_chk(8'h34, 1, "R8 addr");
        send_chk(8'h20, 1, "R8 ptr");
        send_chk(8'h5A, 1, "R8 discard ack");
        bus_stop();
        check_bank("R8 discard");
        bus_start();
        send_chk(8'h34, 1, "R8 addr");
        send_chk(8'hFF, 1, "R8 ptr");
        send_chk(8'h66, 1, "R8 data at FF");
        send_chk(8'h99, 1, "R8 data after wrap");
        bus_stop();
        mdl[8'h00] = 8'h99;
        check_bank("R8 FF wrap");

        // R9 repeated START in mid-transfer
        bus_start();
        send_chk(8'h34, 1, "R9 addr");
        send_chk(8'h02, 1, "R9 ptr");
        send_chk(8'hC1, 1, "R9 data");
        bus_start();
        send_chk(8'h34, 1, "R9 addr after Sr");
        send_chk(8'h04, 1, "R9 ptr after Sr");
        send_chk(8'hC2, 1, "R9 data after Sr");
        bus_stop();
        mdl[8'h02] = 8'hC1; mdl[8'h04] = 8'hC2;
        check_bank("R9 bank");

        // R10 bytes after STOP without a START
        scl = 1'b0; wq();
        send(8'h34, a);
        chk(a == 1'b0, "R10 no ack", a, 0);
        send(8'h07, a);
        chk(a == 1'b0, "R10 no ack", a, 0);
        scl = 1'b1; wq();
        bus_stop();
        check_bank("R10 bank");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule